// File: doc/BRIEF.md
# Presence-Detect Serial EEPROM Target

This block answers on a two-wire serial bus as a small byte-wide EEPROM that holds a 256-byte description of a memory module. The lower half of the image identifies the module: its type, organisation and timing. The upper half is scratch space for the end user. A host reads the description with the usual random, current-address and sequential reads. It can also store single bytes in the user half.

The block runs from a fast system clock and oversamples the SCL and SDA lines. It pulls SDA low through an open-drain enable and never drives the line high. Two strap inputs choose the low two bits of the 7-bit bus address, so up to four modules can share one bus. A preload port lets the surrounding logic overwrite any byte of the image, including the protected half. A status flag compares the stored check byte with the sum of the identification bytes before it.

Top module: `spd_eeprom_target`

## Requirements
- R1: The block acknowledges only the 7-bit address {5'b10100, strap[1:0]} with the direction bit in bit 0, so a write is 0xA0|strap<<1 and a read is 0xA1|strap<<1. Any other address gets no acknowledge, and the block stays silent until the next START.
- R2: A byte write (address byte, word address, data byte) to a word address from 0x80 to 0xFF is acknowledged and stored. A later read returns the stored value.
- R3: A data byte written over the bus to a word address from 0x00 to 0x7F is acknowledged but leaves the image unchanged.
- R4: A random read (write address, word address, repeated START, read address) returns the image byte at that word address.
- R5: A current-address read returns the byte that follows the last byte read or written.
- R6: In a sequential read, each acknowledged byte is followed by the next address. A NACK from the master ends the transfer, and SDA is released.
- R7: The byte pointer steps by one after every data byte, for reads and writes alike, and wraps from 0xFF to 0x00.
- R8: After reset: byte 0x00 = 0x80, 0x01 = 0x08, 0x02 = 0x08, bytes 0x03..0x3E = 0x00, byte 0x3F = 0x90 (their checksum), bytes 0x40..0x7F = 0x00, bytes 0x80..0xFF = 0xFF. The status flag is low and SDA is released.
- R9: The status flag is high exactly when byte 0x3F differs from the low 8 bits of the sum of bytes 0x00..0x3E. It updates two clock cycles after the image changes.
- R10: A preload strobe writes its data to any address, 0x00..0xFF included, on the next clock edge. It takes precedence over a bus write in the same cycle.
- R11: The SDA pull-down is only switched on while SCL is seen low, and it is off in the cycle after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |
| strap | input | 2 | Address straps, bus address bits [1:0] |
| pre_en | input | 1 | Preload write strobe |
| pre_addr | input | 8 | Preload byte address |
| pre_data | input | 8 | Preload byte value |
| csum_bad | output | 1 | High when the check byte does not match the identification sum |

## Verification
The assertions assume that SDA only changes while SCL is low, except for START and STOP. They also assume that every SCL or SDA edge is held for longer than the two-stage input synchroniser, so the sampled lines keep the bus order of events. The bench moves SCL and SDA in separate phases six system clocks apart. It changes the data line only one phase after SCL has fallen, and it changes the straps only while the bus is idle.

// File: rtl/spd_pkg.sv
// Shared constants, state encoding and the power-on image of the presence-detect target.
// Assumes an 8-bit byte address and a checksum byte that follows the bytes it covers.
package spd_pkg;

    localparam logic [4:0] DEV_ID_HI = 5'b10100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_t;

    // Identification bytes before the checksum is inserted.
    function automatic logic [7:0] spd_base_byte(input int idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h08;
            2:       return 8'h08;
            default: return (idx >= 128) ? 8'hFF : 8'h00;
        endcase
    endfunction

    // Power-on value of byte idx; the check byte is computed over the bytes before it.
    function automatic logic [7:0] spd_default_byte(input int idx, input int csum_pos);
        logic [7:0] acc;
        acc = 8'h00;
        if (idx == csum_pos) begin
            for (int j = 0; j < csum_pos; j++) begin
                acc = acc + spd_base_byte(j);
            end
            return acc;
        end
        return spd_base_byte(idx);
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
// Synchronises SCL and SDA into the system clock and finds SCL edges, START and STOP.
// Assumes each bus edge is held for longer than the two-stage synchroniser.
module spd_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_d;
    logic                   sda_d;

    // Shift the raw lines through the synchroniser and keep one previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
            scl_d <= scl_q[SYNC_STAGES-1];
            sda_d <= sda_q[SYNC_STAGES-1];
        end
    end

    // Decode edges and bus conditions from the current and previous samples.
    always_comb begin
        scl_s     = scl_q[SYNC_STAGES-1];
        sda_s     = sda_q[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/spd_image_store.sv
// Holds the byte image; the preload port writes anywhere, the bus writes only the user area.
// Assumes one write per cycle is enough; preload wins over a bus write in the same cycle.
module spd_image_store
    import spd_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PROT_LIMIT = 128,
    parameter int CSUM_POS   = 63
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pre_en,
    input  logic [ADDR_W-1:0]           pre_addr,
    input  logic [7:0]                  pre_data,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [7:0]                  bus_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [7:0]                  rd_data,
    output logic [(CSUM_POS+1)*8-1:0]   head
);

    localparam int              DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_LIMIT);

    logic [7:0] mem [DEPTH];

    // Load the default image on reset, else apply one gated write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= spd_default_byte(i, CSUM_POS);
            end
        end else if (pre_en) begin
            mem[pre_addr] <= pre_data;
        end else if (bus_we && (bus_addr >= PROT_A)) begin
            mem[bus_addr] <= bus_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // Expose the checksummed bytes, lowest address in the lowest byte lane.
    for (genvar g = 0; g <= CSUM_POS; g++) begin : g_head
        assign head[g*8 +: 8] = mem[g];
    end

    // R3: a bus write into the protected area leaves the byte as it was.
    assert_prot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr < PROT_A) && !pre_en) |=> (mem[$past(bus_addr)] == $past(mem[bus_addr])));

endmodule

// File: rtl/spd_csum_check.sv
// Sums the identification bytes and raises a registered flag when the check byte disagrees.
// Assumes the check byte sits directly after the bytes it covers.
module spd_csum_check #(
    parameter int CSUM_POS = 63
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [(CSUM_POS+1)*8-1:0] head,
    output logic                      csum_bad
);

    logic [7:0] sum;

    // Add the covered bytes modulo 256.
    always_comb begin
        sum = 8'h00;
        for (int i = 0; i < CSUM_POS; i++) begin
            sum = sum + head[i*8 +: 8];
        end
    end

    // Register the comparison against the stored check byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csum_bad <= 1'b0;
        end else begin
            csum_bad <= (sum != head[CSUM_POS*8 +: 8]);
        end
    end

endmodule

// File: rtl/spd_bus_fsm.sv
// Serial bus target protocol: address match, word pointer, read and write sequencing.
// Assumes SDA is stable while SCL is high except for START and STOP.
module spd_bus_fsm
    import spd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              sda_pull
);

    localparam int BIT_W = 4;
    localparam logic [BIT_W-1:0] FULL = BIT_W'(8);

    bus_state_t       state;
    logic [BIT_W-1:0] bit_cnt;
    logic [7:0]       shreg;
    logic             rw;
    logic             mack;

    // Protocol sequencer: conditions first, then SCL rising and falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= ST_DEV;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (scl_rise) begin
                case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_RDATA: bit_cnt <= bit_cnt + 1'b1;
                    ST_RACK:  mack    <= ~sda_s;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state)
                    ST_DEV: if (bit_cnt == FULL) begin
                        bit_cnt <= '0;
                        if (shreg[7:1] == {DEV_ID_HI, strap}) begin
                            rw       <= shreg[0];
                            sda_pull <= 1'b1;
                            state    <= ST_DEV_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_DEV_ACK: if (rw) begin
                        shreg    <= rd_data;
                        sda_pull <= ~rd_data[7];
                        state    <= ST_RDATA;
                    end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_WADDR;
                    end
                    ST_WADDR: if (bit_cnt == FULL) begin
                        bit_cnt  <= '0;
                        ptr      <= shreg[ADDR_W-1:0];
                        sda_pull <= 1'b1;
                        state    <= ST_WADDR_ACK;
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        sda_pull <= 1'b0;
                        state    <= ST_WDATA;
                    end
                    ST_WDATA: if (bit_cnt == FULL) begin
                        bit_cnt  <= '0;
                        wr_en    <= 1'b1;
                        wr_addr  <= ptr;
                        wr_data  <= shreg;
                        ptr      <= ptr + 1'b1;
                        sda_pull <= 1'b1;
                        state    <= ST_WDATA_ACK;
                    end
                    ST_RDATA: if (bit_cnt == FULL) begin
                        bit_cnt  <= '0;
                        sda_pull <= 1'b0;
                        ptr      <= ptr + 1'b1;
                        state    <= ST_RACK;
                    end else begin
                        shreg    <= {shreg[6:0], 1'b0};
                        sda_pull <= ~shreg[6];
                    end
                    ST_RACK: if (mack) begin
                        shreg    <= rd_data;
                        sda_pull <= ~rd_data[7];
                        state    <= ST_RDATA;
                    end else begin
                        sda_pull <= 1'b0;
                        state    <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the pull-down is only switched on while SCL is low.
    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R11: a STOP leaves SDA released.
    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // R7: a pointer step from the top address lands on zero.
    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ptr) == '1) && (ptr != $past(ptr)) && !$past(state == ST_WADDR)) |-> (ptr == '0));

    // R1: entering the address acknowledge always pulls SDA low.
    assert_dev_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DEV && state == ST_DEV_ACK) |-> sda_pull);

endmodule

// File: rtl/spd_eeprom_target.sv
// Top of the presence-detect EEPROM target: line sync, protocol, image store and checksum.
// Assumes clk runs many times faster than SCL; SDA is open drain via sda_pull.
module spd_eeprom_target #(
    parameter int ADDR_W      = 8,
    parameter int PROT_LIMIT  = 128,
    parameter int CSUM_POS    = 63,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [1:0]        strap,
    input  logic              pre_en,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [7:0]        pre_data,
    output logic              csum_bad
);

    localparam int HEAD_W = (CSUM_POS + 1) * 8;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [ADDR_W-1:0] ptr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;
    logic [HEAD_W-1:0] head;

    spd_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    spd_bus_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .strap(strap), .rd_data(rd_data), .ptr(ptr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_pull(sda_pull)
    );

    spd_image_store #(.ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT), .CSUM_POS(CSUM_POS)) store_i (
        .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .pre_addr(pre_addr),
        .pre_data(pre_data), .bus_we(wr_en), .bus_addr(wr_addr), .bus_data(wr_data),
        .rd_addr(ptr), .rd_data(rd_data), .head(head)
    );

    spd_csum_check #(.CSUM_POS(CSUM_POS)) csum_i (
        .clk(clk), .rst_n(rst_n), .head(head), .csum_bad(csum_bad)
    );

endmodule

// File: tb/spd_eeprom_target_tb_top.sv
// Self-checking bench: vector table of byte writes and random reads, then directed tests.
module spd_eeprom_target_tb_top;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       pre_en = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic       sda_pull;
    logic       csum_bad;
    logic       sda_line;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] model [0:255];
    logic [7:0] rbuf  [0:7];

    assign sda_line = sda_m & ~sda_pull;

    always #2.5 clk = ~clk;

    spd_eeprom_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
        .strap(strap), .pre_en(pre_en), .pre_addr(pre_addr), .pre_data(pre_data),
        .csum_bad(csum_bad)
    );

    // op (1 = byte write, 0 = random read), word address, data
    localparam logic [16:0] VEC [0:10] = '{
        {1'b1, 8'h80, 8'h5A}, {1'b0, 8'h80, 8'h00}, {1'b1, 8'h10, 8'h33},
        {1'b0, 8'h10, 8'h00}, {1'b0, 8'h00, 8'h00}, {1'b0, 8'h02, 8'h00},
        {1'b1, 8'hFF, 8'hC3}, {1'b0, 8'hFF, 8'h00}, {1'b0, 8'h3F, 8'h00},
        {1'b1, 8'h00, 8'h11}, {1'b0, 8'h00, 8'h00}
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl = 1'b0; wq();
        end
        sda_m = ~give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_w();
        return {5'b10100, strap, 1'b0};
    endfunction

    function automatic logic [7:0] model_sum();
        logic [7:0] s;
        s = '0;
        for (int i = 0; i < 63; i++) s = s + model[i];
        return s;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, output logic all_ack);
        logic k1, k2, k3;
        i2c_start(); send_byte(dev_w(), k1); send_byte(a, k2); send_byte(d, k3); i2c_stop();
        all_ack = k1 & k2 & k3;
        if (a >= 8'h80) model[a] = d;
    endtask

    task automatic read_body(input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            rbuf[i] = v;
        end
        i2c_stop();
    endtask

    task automatic rand_read(input logic [7:0] a, input int n);
        logic k;
        i2c_start(); send_byte(dev_w(), k); send_byte(a, k);
        i2c_start(); send_byte(dev_w() | 8'h01, k);
        read_body(n);
    endtask

    task automatic cur_read(input int n);
        logic k;
        i2c_start(); send_byte(dev_w() | 8'h01, k);
        read_body(n);
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(posedge clk); #1;
        pre_en = 1'b0;
        model[a] = d;
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ok;
        logic k;
        for (int i = 0; i < 256; i++) begin
            model[i] = (i >= 128) ? 8'hFF : 8'h00;
        end
        model[0] = 8'h80; model[1] = 8'h08; model[2] = 8'h08; model[63] = 8'h90;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check8("R8 reset flag", {7'b0, csum_bad}, 8'h00);
        check8("R8 reset sda", {7'b0, sda_pull}, 8'h00);

        // Vector table: byte writes (R2/R3) and random reads (R4/R8).
        for (int i = 0; i < 11; i++) begin
            if (VEC[i][16]) begin
                bus_write(VEC[i][15:8], VEC[i][7:0], ok);
                check8(VEC[i][15] ? "R2 write ack" : "R3 write ack", {7'b0, ok}, 8'h01);
            end else begin
                rand_read(VEC[i][15:8], 1);
                check8(VEC[i][15] ? "R4 read" : "R8 R3 read", rbuf[0], model[VEC[i][15:8]]);
            end
        end

        // R1: wrong addresses get no acknowledge; a strap change moves the address.
        i2c_start(); send_byte(8'hA0, k); i2c_stop();
        check8("R1 other strap nack", {7'b0, k}, 8'h00);
        i2c_start(); send_byte(8'hB4, k); i2c_stop();
        check8("R1 other id nack", {7'b0, k}, 8'h00);
        strap = 2'b01;
        i2c_start(); send_byte(8'hA2, k); i2c_stop();
        check8("R1 new strap ack", {7'b0, k}, 8'h01);
        strap = 2'b10;

        // R5: current-address read follows the last read.
        bus_write(8'h81, 8'h77, ok);
        rand_read(8'h80, 1);
        cur_read(1);
        check8("R5 current read", rbuf[0], 8'h77);

        // R6: sequential read with master ACKs, NACK on the last byte.
        rand_read(8'h00, 4);
        for (int i = 0; i < 4; i++) check8("R6 sequential", rbuf[i], model[i]);
        check8("R6 released after nack", {7'b0, sda_pull}, 8'h00);
        cur_read(1);
        check8("R6 R5 pointer after seq", rbuf[0], model[4]);

        // R7: sequential write across the top wraps; the byte at 0x00 is discarded (R3).
        i2c_start(); send_byte(dev_w(), k); send_byte(8'hFE, k);
        send_byte(8'hA1, k); send_byte(8'hA2, k); send_byte(8'hA3, k);
        check8("R3 wrapped write ack", {7'b0, k}, 8'h01);
        i2c_stop();
        model[8'hFE] = 8'hA1; model[8'hFF] = 8'hA2;
        cur_read(1);
        check8("R7 write wrap pointer", rbuf[0], model[1]);
        rand_read(8'hFE, 3);
        check8("R7 read FE", rbuf[0], 8'hA1);
        check8("R7 read FF", rbuf[1], 8'hA2);
        check8("R7 read wrap 00", rbuf[2], model[0]);

        // R9 / R10: preload into the protected area and the checksum flag.
        preload(8'h05, 8'h01);
        check8("R9 flag on mismatch", {7'b0, csum_bad}, {7'b0, model_sum() != model[63]});
        rand_read(8'h05, 1);
        check8("R10 preload protected", rbuf[0], 8'h01);
        preload(8'h3F, 8'h91);
        check8("R9 flag clear on fix", {7'b0, csum_bad}, 8'h00);
        preload(8'h05, 8'h00);
        check8("R9 flag set again", {7'b0, csum_bad}, 8'h01);
        preload(8'h3F, 8'h90);
        check8("R9 flag clear default", {7'b0, csum_bad}, 8'h00);
        preload(8'hC0, 8'h3C);
        rand_read(8'hC0, 1);
        check8("R10 preload user", rbuf[0], 8'h3C);

        // R8: a fresh reset restores the image.
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rand_read(8'h80, 1);
        check8("R8 user area reset", rbuf[0], 8'hFF);
        rand_read(8'h3F, 1);
        check8("R8 checksum byte", rbuf[0], 8'h90);
        check8("R11 idle release", {7'b0, sda_pull}, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule